// File: doc/BRIEF.md
# Low-Power Compare Timer Core

This block is a single-clock up-counter with a compare value, meant to sit beside an external prescaler. In time mode it advances once for every cycle in which the prescaler's tick input is high. In pulse mode it advances once per qualifying edge on one of four external inputs. The active edge is chosen by a polarity bit. When the count already equals the compare value and another advance arrives, a sticky match flag sets. Depending on a policy bit, the counter then either restarts from zero or keeps running and wraps only when it overflows. The flag is gated by two enables to form an interrupt output and a DMA request output.

Software reaches the block through a plain write-strobe and byte-address register port with four 32-bit words. Offset 0x0 holds the configuration and status word. Offset 0x4 holds a prescaler setting that the block only stores and forwards to the separate prescaler. Offset 0x8 holds the compare value and offset 0xC returns the live count. A write whose address is not word-aligned has no effect.

Top module: `lp_cmp_timer`

## Requirements
- R1: After reset, all four registers read 0, the prescaler setting output is 0, and the interrupt and DMA outputs are 0.
- R2: While the enable (word 0x0, bit 0) is 0, the counter reads 0 and ignores ticks. Clearing the enable also clears the match flag (bit 7).
- R3: In time mode (bit 1 = 0) with the enable set, each clock cycle with the tick input high adds one to the count, as long as the count differs from the compare value.
- R4: With the policy bit (bit 2) at 0, an advance while the count equals the compare value sets the flag and returns the count to 0. This includes a compare value of 0.
- R5: With the policy bit at 1, an advance at a match sets the flag and the count still adds one. After all-ones the count wraps to 0.
- R6: In pulse mode (bit 1 = 1) with polarity bit 3 at 0, each rising edge of the selected input adds exactly one, however long the input stays high.
- R7: With polarity bit 3 at 1, falling edges are counted and rising edges are not.
- R8: Bits 5:4 select which input is counted (value n selects input n). Edges on the other inputs leave the count unchanged.
- R9: Writing 1 to bit 7 of word 0x0 clears the flag. Writing 0 there leaves it unchanged.
- R10: The interrupt output equals the flag AND bit 6. The DMA output equals the flag AND bit 8.
- R11: While the enable is 1, writes to bits 1 to 5 of word 0x0 are ignored. Bits 0, 6 and 8 still take the written value.
- R12: Writes to word 0xC have no effect. Word 0x4 keeps its low 7 bits, reads them back, and drives them on the prescaler setting output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tick_i | input | 1 | Count-enable tick from the external prescaler |
| pulse_in | input | 4 | External pulse inputs |
| presc_cfg_o | output | 7 | Stored prescaler setting |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |

## Verification
The bench builds the block with an 8-bit counter (CNT_W = 8) and keeps the four pulse inputs. With the narrow counter, the all-ones wrap of the free-running policy is reached in 256 ticks instead of four billion. The same holds for a match at the top of the count range. The four inputs let one test count on a selected pin while another pin toggles without effect.

// File: rtl/lpt_pkg.sv
`timescale 1ns/1ps
// Package: shared register word indices and control bit positions for
// the compare timer. Assumes a 16-byte window decoded on address bits 3:2.
package lpt_pkg;
    typedef enum logic [1:0] {
        W_CTRL = 2'd0,
        W_PRE  = 2'd1,
        W_CMP  = 2'd2,
        W_CNT  = 2'd3
    } word_e;

    localparam int B_EN   = 0;
    localparam int B_MODE = 1;
    localparam int B_FREE = 2;
    localparam int B_POL  = 3;
    localparam int B_SEL  = 4;
    localparam int B_IE   = 6;
    localparam int B_FLAG = 7;
    localparam int B_DE   = 8;
endpackage

// File: rtl/lpt_regs.sv
`timescale 1ns/1ps
// Register bank: holds the configuration, prescaler setting and compare value.
// It produces the read mux and the flag-clear strobe. Assumes the flag and
// the count come from the counter core. Locked bits change only while the
// block is disabled.
module lpt_regs
    import lpt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 7,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       addr,
    input  logic [31:0]      wdata,
    input  logic             flag_q,
    input  logic [CNT_W-1:0] cnt_q,
    output logic [31:0]      rdata,
    output logic             en_q,
    output logic             mode_q,
    output logic             free_q,
    output logic             pol_q,
    output logic [SEL_W-1:0] sel_q,
    output logic             ie_q,
    output logic             de_q,
    output logic [PRE_W-1:0] pre_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             flag_clr
);
    logic  aligned;
    word_e widx;

    assign aligned = (addr[1:0] == 2'b00);
    assign widx    = word_e'(addr[3:2]);
    // Write-one-to-clear request for the match flag.
    assign flag_clr = wr_en && aligned && (widx == W_CTRL) && wdata[B_FLAG];

    // Configuration word: the free bits always update, the locked bits only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= 1'b0;
            free_q <= 1'b0;
            pol_q  <= 1'b0;
            sel_q  <= '0;
            ie_q   <= 1'b0;
            de_q   <= 1'b0;
        end else if (wr_en && aligned && widx == W_CTRL) begin
            en_q <= wdata[B_EN];
            ie_q <= wdata[B_IE];
            de_q <= wdata[B_DE];
            if (!en_q) begin
                mode_q <= wdata[B_MODE];
                free_q <= wdata[B_FREE];
                pol_q  <= wdata[B_POL];
                sel_q  <= wdata[B_SEL +: SEL_W];
            end
        end
    end

    // Prescaler setting and compare value storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            cmp_q <= '0;
        end else if (wr_en && aligned) begin
            if (widx == W_PRE) pre_q <= wdata[PRE_W-1:0];
            if (widx == W_CMP) cmp_q <= wdata[CNT_W-1:0];
        end
    end

    // Read mux for the word selected by the address.
    always_comb begin
        rdata = '0;
        unique case (widx)
            W_CTRL: begin
                rdata[B_EN]            = en_q;
                rdata[B_MODE]          = mode_q;
                rdata[B_FREE]          = free_q;
                rdata[B_POL]           = pol_q;
                rdata[B_SEL +: SEL_W]  = sel_q;
                rdata[B_IE]            = ie_q;
                rdata[B_FLAG]          = flag_q;
                rdata[B_DE]            = de_q;
            end
            W_PRE:   rdata[PRE_W-1:0] = pre_q;
            W_CMP:   rdata[CNT_W-1:0] = cmp_q;
            W_CNT:   rdata[CNT_W-1:0] = cnt_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/lpt_edge.sv
`timescale 1ns/1ps
// Pulse front end: picks one input, normalises its polarity and registers
// it through STAGES flops. It emits a one-cycle strobe per active edge.
// Assumes the select and polarity are stable while enabled. The flops clear
// while disabled, so they hold the inactive level.
module lpt_edge #(
    parameter int N_PINS = 4,
    parameter int SEL_W  = 2,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              pol,
    input  logic [SEL_W-1:0]  sel,
    input  logic [N_PINS-1:0] pins,
    output logic              edge_o
);
    localparam int LAST = STAGES - 1;

    logic             active_lvl;
    logic [LAST:0]    shreg;

    assign active_lvl = pins[sel] ^ pol;

    // Sampling chain for the normalised input; cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) shreg <= '0;
        else               shreg <= {shreg[LAST-1:0], active_lvl};
    end

    // The newest two samples differ inactive-to-active: one count.
    assign edge_o = shreg[LAST-1] & ~shreg[LAST];
endmodule

// File: rtl/lpt_core.sv
`timescale 1ns/1ps
// Counter core: the up-counter and the sticky match flag. A match advance
// either restarts the count or lets it run on, depending on the policy bit.
// Assumes one advance per cycle at most. Everything clears while disabled.
module lpt_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             free,
    input  logic             adv,
    input  logic [CNT_W-1:0] cmp,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             flag_q
);
    logic hit;

    assign hit = adv && (cnt_q == cmp);

    // Counter update: restart on a match unless free running, else step and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)   cnt_q <= '0;
        else if (hit && !free) cnt_q <= '0;
        else if (adv)        cnt_q <= cnt_q + 1'b1;
    end

    // Match flag: set wins over a same-cycle clear request.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) flag_q <= 1'b0;
        else if (hit)      flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end
endmodule

// File: rtl/lp_cmp_timer.sv
`timescale 1ns/1ps
// Top level of the compare timer. It joins the register bank, the pulse
// front end and the counter core, and chooses the advance source by mode.
// Assumes a single clock and a tick input already prescaled and one cycle
// wide per period. Supports at most four pulse inputs in the select field.
module lp_cmp_timer #(
    parameter int CNT_W  = 32,
    parameter int N_PINS = 4,
    parameter int PRE_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tick_i,
    input  logic [N_PINS-1:0] pulse_in,
    output logic [PRE_W-1:0]  presc_cfg_o,
    output logic              irq_o,
    output logic              dma_req_o
);
    localparam int SEL_W = (N_PINS > 1) ? $clog2(N_PINS) : 1;

    logic             en_q, mode_q, free_q, pol_q, ie_q, de_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cmp_q, cnt_q;
    logic             flag_q, flag_clr, pin_edge, adv;

    lpt_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .SEL_W(SEL_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .flag_q(flag_q), .cnt_q(cnt_q), .rdata(reg_rdata),
        .en_q(en_q), .mode_q(mode_q), .free_q(free_q), .pol_q(pol_q),
        .sel_q(sel_q), .ie_q(ie_q), .de_q(de_q), .pre_q(presc_cfg_o),
        .cmp_q(cmp_q), .flag_clr(flag_clr)
    );

    lpt_edge #(.N_PINS(N_PINS), .SEL_W(SEL_W), .STAGES(2)) edge_i (
        .clk(clk), .rst_n(rst_n), .en(en_q), .pol(pol_q), .sel(sel_q),
        .pins(pulse_in), .edge_o(pin_edge)
    );

    // Advance source: edge strobe in pulse mode, prescaled tick otherwise.
    assign adv = mode_q ? pin_edge : tick_i;

    lpt_core #(.CNT_W(CNT_W)) core_i (
        .clk(clk), .rst_n(rst_n), .en(en_q), .free(free_q), .adv(adv),
        .cmp(cmp_q), .flag_clr(flag_clr), .cnt_q(cnt_q), .flag_q(flag_q)
    );

    // Request outputs gated by their enables.
    assign irq_o     = flag_q & ie_q;
    assign dma_req_o = flag_q & de_q;
endmodule

// File: rtl/lpt_checker.sv
`timescale 1ns/1ps
// Checker for the compare timer. It watches the configuration, the count
// and the flag across cycles. It is attached to every instance of the top
// through the bind below.
module lpt_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_q,
    input logic             mode_q,
    input logic             free_q,
    input logic             adv,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] cmp_q,
    input logic             flag_q,
    input logic             irq_o,
    input logic             dma_req_o
);
    // R2: a disabled cycle leaves count and flag cleared.
    a_r2_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (cnt_q == '0) && !flag_q);

    // R3: a non-matching advance steps the count by one.
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && adv && (cnt_q != cmp_q) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R4: restart policy returns to zero on a match and sets the flag.
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && !free_q && adv && (cnt_q == cmp_q) |=> (cnt_q == '0) && flag_q);

    // R5: free-running policy keeps stepping through a match.
    a_r5_run_on: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && free_q && adv && (cnt_q == cmp_q)
        |=> flag_q && (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R10: no request output without the flag.
    a_r10_no_req_without_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_q |-> !irq_o && !dma_req_o);

    // R11: locked configuration holds across enabled cycles.
    a_r11_locked_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && $past(en_q) |-> $stable(mode_q) && $stable(free_q));
endmodule

bind lp_cmp_timer lpt_checker #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .mode_q(mode_q), .free_q(free_q),
    .adv(adv), .cnt_q(cnt_q), .cmp_q(cmp_q), .flag_q(flag_q),
    .irq_o(irq_o), .dma_req_o(dma_req_o)
);

// File: tb/lp_cmp_timer_tb_top.sv
`timescale 1ns/1ps
// Bench for the compare timer: a table of time-mode vectors, then directed
// tests for reset, pulse counting, flag handling and register locking.
module lp_cmp_timer_tb_top;
    localparam int CW = 8;
    localparam int NP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick_i = 1'b0;
    logic [NP-1:0] pulse_in = '0;
    logic [6:0]  presc_cfg_o;
    logic        irq_o, dma_req_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    lp_cmp_timer #(.CNT_W(CW), .N_PINS(NP), .PRE_W(7)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_i(tick_i),
        .pulse_in(pulse_in), .presc_cfg_o(presc_cfg_o), .irq_o(irq_o),
        .dma_req_o(dma_req_o)
    );

    typedef struct packed {
        logic [8:0] cfg;
        logic [7:0] cmp;
        logic [9:0] n;
        logic [7:0] exp_cnt;
        logic       exp_flag;
    } vec_t;

    // cfg 0x001 = enable, restart policy; 0x005 = enable, free running.
    localparam vec_t VEC [8] = '{
        '{9'h001, 8'd10,  10'd5,   8'd5, 1'b0},
        '{9'h001, 8'd3,   10'd4,   8'd0, 1'b1},
        '{9'h001, 8'd3,   10'd6,   8'd2, 1'b1},
        '{9'h005, 8'd3,   10'd6,   8'd6, 1'b1},
        '{9'h005, 8'd200, 10'd10,  8'd10, 1'b0},
        '{9'h001, 8'd0,   10'd3,   8'd0, 1'b1},
        '{9'h005, 8'd255, 10'd256, 8'd0, 1'b1},
        '{9'h005, 8'd255, 10'd258, 8'd2, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic pulse(input int pin, input logic lvl);
        @(negedge clk);
        pulse_in[pin] = lvl;
        repeat (4) @(negedge clk);
        pulse_in[pin] = ~lvl;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every word and output.
        for (int a = 0; a < 16; a += 4) begin
            rd(4'(a), d);
            chk("R1 reset readback", d, 32'h0);
        end
        chk("R1 outputs", {presc_cfg_o, irq_o, dma_req_o}, 32'h0);

        // R2: ticks ignored while disabled.
        ticks(5);
        rd(4'hC, d);
        chk("R2 disabled count", d, 32'h0);

        // Table: time-mode count, restart and free-running policies (R3 R4 R5).
        for (int i = 0; i < 8; i++) begin
            wr(4'h0, 32'h0);
            wr(4'h8, {24'h0, VEC[i].cmp});
            wr(4'h0, {23'h0, VEC[i].cfg});
            ticks(int'(VEC[i].n));
            rd(4'hC, d);
            chk($sformatf("R3 R4 R5 vector %0d count", i), d, {24'h0, VEC[i].exp_cnt});
            rd(4'h0, d);
            chk($sformatf("R4 R5 vector %0d flag", i), {31'h0, d[7]}, {31'h0, VEC[i].exp_flag});
        end

        // R2: disabling clears flag and count (flag is set from the last vector).
        wr(4'h0, 32'h0);
        rd(4'h0, d);
        chk("R2 flag cleared by disable", {31'h0, d[7]}, 32'h0);
        rd(4'hC, d);
        chk("R2 count cleared by disable", d, 32'h0);

        // R9 and R10: set flag with compare 1 and two ticks.
        wr(4'h8, 32'h1);
        wr(4'h0, 32'h1);
        ticks(2);
        chk("R10 irq off without enable", {31'h0, irq_o}, 32'h0);
        wr(4'h0, 32'h041);
        chk("R10 irq follows flag", {30'h0, irq_o, dma_req_o}, 32'h2);
        wr(4'h0, 32'h141);
        chk("R10 dma follows flag", {30'h0, irq_o, dma_req_o}, 32'h3);
        rd(4'h0, d);
        chk("R9 flag kept by zero write", {31'h0, d[7]}, 32'h1);
        wr(4'h0, 32'h1C1);
        rd(4'h0, d);
        chk("R9 flag cleared by one write", {31'h0, d[7]}, 32'h0);
        chk("R10 requests drop with flag", {30'h0, irq_o, dma_req_o}, 32'h0);

        // R6 and R8: rising edges on input 0, pulse mode.
        wr(4'h0, 32'h0);
        wr(4'h8, 32'hFF);
        wr(4'h0, 32'h003);
        pulse(0, 1'b1);
        pulse(0, 1'b1);
        pulse(0, 1'b1);
        rd(4'hC, d);
        chk("R6 one count per rising edge", d, 32'h3);
        pulse(1, 1'b1);
        rd(4'hC, d);
        chk("R8 unselected input ignored", d, 32'h3);

        // R7 and R8: falling edges on input 2, pins idle high.
        wr(4'h0, 32'h0);
        pulse_in = '1;
        wr(4'h0, 32'h02B);
        pulse(2, 1'b0);
        rd(4'hC, d);
        chk("R7 falling edge counted", d, 32'h1);
        pulse(2, 1'b0);
        rd(4'hC, d);
        chk("R7 second falling edge", d, 32'h2);
        pulse(3, 1'b0);
        rd(4'hC, d);
        chk("R8 input 3 ignored when 2 selected", d, 32'h2);

        // R11: locked fields ignore writes while enabled; ie still updates.
        wr(4'h0, 32'h041);
        rd(4'h0, d);
        chk("R11 locked fields held", d & 32'h17F, 32'h06B);

        // R12: counter word not writable; prescale word stores 7 bits.
        wr(4'hC, 32'h55);
        rd(4'hC, d);
        chk("R12 counter write ignored", d, 32'h2);
        wr(4'h4, 32'h5A);
        rd(4'h4, d);
        chk("R12 prescale readback", d, 32'h5A);
        chk("R12 prescale output", {25'h0, presc_cfg_o}, 32'h5A);
        wr(4'h4, 32'hFF);
        rd(4'h4, d);
        chk("R12 prescale width", d, 32'h7F);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule